// File: doc/BRIEF.md
# Link Integrity Monitor for a 100 Mb/s Receive Path

This block decides whether a 100 Mb/s copper link is fit to carry data. It watches a signal-detect level from the analog front end. Before it will call the link usable, that level must stay high for a settle interval. The settle interval is a parameter counted in clock cycles; its default of 50,000 cycles is 500 µs at 100 MHz. Once the interval has passed, the monitor enters a ready state. If auto-negotiation is enabled, it holds there until auto-negotiation gives a go. If auto-negotiation is disabled, it moves straight on to link-up.

While the link is up, an enable output opens the transmit and receive data paths. In every other state the paths stay closed. The link drops back to idle in two cases: signal detect falls in any state, or the descrambler loses lock during link-up. A single reportable status bit is also produced. It carries the 100 Mb/s result or an external 10 Mb/s link status, chosen by the active speed.

Top module: `lnk_monitor_top`

## Requirements
- R1: `link_ready` rises on the clock edge at which `sig_det` has been sampled high on SETTLE_CYC consecutive edges while the monitor is idle, and not on any earlier edge.
- R2: With `an_enable` low, the monitor spends exactly one cycle in ready (`link_ready`=1) and enters link-up on the next edge.
- R3: With `an_enable` high, the monitor stays in ready for as long as `an_go` is sampled low, and enters link-up on the edge at which `an_go` is sampled high.
- R4: `sig_det` sampled low in any state returns the monitor to idle (`link_ready`=0, `link_up`=0) on that edge. A full SETTLE_CYC run of high samples is then needed again.
- R5: `dscr_lock` sampled low while in link-up returns the monitor to idle on that edge.
- R6: `dpath_en` is 1 exactly while `link_up` is 1, and 0 in idle and in ready.
- R7: `link_status` equals `link_up` when `speed_100` is 1, and equals `link10_ok` when `speed_100` is 0, with no clock delay.
- R8: After reset, `link_ready`, `link_up` and `dpath_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_det | input | 1 | Signal energy present on the line |
| dscr_lock | input | 1 | Descrambler is locked |
| an_enable | input | 1 | Auto-negotiation is enabled |
| an_go | input | 1 | Auto-negotiation allows link-up |
| speed_100 | input | 1 | 1 selects 100 Mb/s status, 0 selects 10 Mb/s |
| link10_ok | input | 1 | Link status from the 10 Mb/s path |
| link_ready | output | 1 | Monitor is in the ready state |
| link_up | output | 1 | Monitor is in the link-up state |
| dpath_en | output | 1 | Transmit/receive data path enable |
| link_status | output | 1 | Reportable link status bit |

## Verification
Internal state is decoded straight onto `link_ready` and `link_up`, so a wrong state shows up at the ports on the very edge it is entered.

A persistence counter that is off by one, or that is not cleared when `sig_det` drops, moves the rise of `link_ready` by at least one cycle. The bench therefore counts edges exactly and checks the cycle before the rise as well as the cycle of the rise. Any missed exit from link-up leaves `link_up` and `dpath_en` high one edge after the fault. The bench checks those outputs on that edge.

// File: rtl/lnk_pkg.sv
// Package: shared state encoding for the link integrity monitor.
// Assumes: one-hot decoding is not needed; states are compared directly.
package lnk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_UP    = 2'd2
    } lnk_state_e;
endpackage

// File: rtl/lnk_settle_timer.sv
// Persistence timer: counts consecutive armed cycles and pulses 'done' on
// the cycle in which the SETTLE_CYC-th consecutive armed sample occurs.
// Assumes: SETTLE_CYC >= 2; clearing happens whenever 'arm' is low.
module lnk_settle_timer #(
    parameter int SETTLE_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Terminal condition: this armed sample completes the run.
    always_comb begin
        done = arm && (cnt_q == LAST);
    end

    // Counter: advance while armed, restart on completion or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_state_ctrl.sv
// State controller: idle -> ready -> up, with drops to idle on loss of
// signal (any state) or descrambler lock (up state only).
// Assumes: settle_done is only asserted while in idle with signal present.
module lnk_state_ctrl
    import lnk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_det,
    input  logic       dscr_lock,
    input  logic       an_enable,
    input  logic       an_go,
    input  logic       settle_done,
    output lnk_state_e state
);
    lnk_state_e nxt;

    // Next-state decision for the three link states.
    always_comb begin
        nxt = state;
        if (!sig_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (settle_done) nxt = ST_READY;
                ST_READY: if (!an_enable || an_go) nxt = ST_UP;
                ST_UP:    if (!dscr_lock) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/lnk_status_sel.sv
// Status selector: picks the reportable link bit by active speed.
// Assumes: speed_100 is already stable from the speed resolution logic.
module lnk_status_sel (
    input  logic speed_100,
    input  logic up100,
    input  logic link10_ok,
    output logic status
);
    // Speed-dependent choice of link status source.
    always_comb begin
        status = speed_100 ? up100 : link10_ok;
    end
endmodule

// File: rtl/lnk_monitor_top.sv
// Link integrity monitor top: ties the persistence timer, state controller
// and status selector together and decodes the state onto the outputs.
// Assumes: all inputs are synchronous to clk.
module lnk_monitor_top
    import lnk_pkg::*;
#(
    parameter int SETTLE_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_det,
    input  logic dscr_lock,
    input  logic an_enable,
    input  logic an_go,
    input  logic speed_100,
    input  logic link10_ok,
    output logic link_ready,
    output logic link_up,
    output logic dpath_en,
    output logic link_status
);
    lnk_state_e state;
    logic       timer_arm;
    logic       settle_done;

    // Arm the timer only while idle and signal is present.
    always_comb begin
        timer_arm = (state == ST_IDLE) && sig_det;
    end

    lnk_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (timer_arm),
        .done  (settle_done)
    );

    lnk_state_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_det     (sig_det),
        .dscr_lock   (dscr_lock),
        .an_enable   (an_enable),
        .an_go       (an_go),
        .settle_done (settle_done),
        .state       (state)
    );

    // State decode onto the link outputs.
    always_comb begin
        link_ready = (state == ST_READY);
        link_up    = (state == ST_UP);
        dpath_en   = (state == ST_UP);
    end

    lnk_status_sel u_sel (
        .speed_100 (speed_100),
        .up100     (link_up),
        .link10_ok (link10_ok),
        .status    (link_status)
    );
endmodule

// File: rtl/lnk_monitor_chk.sv
// Checker: port-level properties of the link integrity monitor.
// Assumes: bound to lnk_monitor_top; uses its own run counter for the
// settle window so no long $past chain is needed.
module lnk_monitor_chk #(
    parameter int SETTLE_CYC = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic sig_det,
    input logic dscr_lock,
    input logic an_enable,
    input logic an_go,
    input logic link_ready,
    input logic link_up,
    input logic dpath_en
);
    int run_q;

    // Count consecutive idle edges with signal present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (sig_det && !link_ready && !link_up) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    p_settle_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> (run_q == SETTLE_CYC));

    p_an_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ready && !an_enable && sig_det) |=> link_up);

    p_an_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ready && an_enable && !an_go && sig_det) |=> (link_ready && !link_up));

    p_sig_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_det |=> (!link_ready && !link_up));

    p_lock_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !dscr_lock) |=> !link_up);

    p_en_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpath_en) |-> $past(link_ready));
endmodule

bind lnk_monitor_top lnk_monitor_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_det    (sig_det),
    .dscr_lock  (dscr_lock),
    .an_enable  (an_enable),
    .an_go      (an_go),
    .link_ready (link_ready),
    .link_up    (link_up),
    .dpath_en   (dpath_en)
);

// File: tb/lnk_monitor_top_bench.sv
// Directed bench for the link integrity monitor; each task checks itself.
module lnk_monitor_top_bench;
    localparam int SET = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_det = 1'b0, dscr_lock = 1'b1, an_enable = 1'b0, an_go = 1'b0;
    logic speed_100 = 1'b1, link10_ok = 1'b0;
    logic link_ready, link_up, dpath_en, link_status;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lnk_monitor_top #(.SETTLE_CYC(SET)) u_lnk_monitor_top (
        .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .dscr_lock(dscr_lock),
        .an_enable(an_enable), .an_go(an_go), .speed_100(speed_100),
        .link10_ok(link10_ok), .link_ready(link_ready), .link_up(link_up),
        .dpath_en(dpath_en), .link_status(link_status)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        chk("R8 ready", link_ready, 1'b0);
        chk("R8 up", link_up, 1'b0);
        chk("R8 dpath_en", dpath_en, 1'b0);
        chk("R7 status100 at reset", link_status, 1'b0);
    endtask

    task automatic t_settle_an_off();
        an_enable = 1'b0;
        sig_det = 1'b1;
        tick(SET - 1);
        chk("R1 not early", link_ready, 1'b0);
        tick(1);
        chk("R1 ready on time", link_ready, 1'b1);
        chk("R6 no enable in ready", dpath_en, 1'b0);
        tick(1);
        chk("R2 up after one ready cycle", link_up, 1'b1);
        chk("R2 ready cleared", link_ready, 1'b0);
        chk("R6 enable in up", dpath_en, 1'b1);
        speed_100 = 1'b1; #1;
        chk("R7 status follows up", link_status, 1'b1);
        speed_100 = 1'b0; link10_ok = 1'b0; #1;
        chk("R7 status follows 10M low", link_status, 1'b0);
        link10_ok = 1'b1; #1;
        chk("R7 status follows 10M high", link_status, 1'b1);
        speed_100 = 1'b1;
    endtask

    task automatic t_lock_loss();
        dscr_lock = 1'b0;
        tick(1);
        chk("R5 up dropped", link_up, 1'b0);
        chk("R6 enable dropped", dpath_en, 1'b0);
        dscr_lock = 1'b1;
        tick(SET - 1);
        chk("R1 restart not early", link_ready, 1'b0);
        tick(1);
        chk("R1 restart ready", link_ready, 1'b1);
    endtask

    task automatic t_an_wait();
        sig_det = 1'b0;
        tick(1);
        chk("R4 drop from up/ready", link_up | link_ready, 1'b0);
        an_enable = 1'b1; an_go = 1'b0; sig_det = 1'b1;
        tick(SET);
        chk("R1 ready with AN on", link_ready, 1'b1);
        tick(5);
        chk("R3 still ready", link_ready, 1'b1);
        chk("R3 not up", link_up, 1'b0);
        an_go = 1'b1;
        tick(1);
        chk("R3 up after go", link_up, 1'b1);
        an_go = 1'b0;
    endtask

    task automatic t_drop_midcount();
        sig_det = 1'b0;
        tick(1);
        chk("R4 idle after drop", link_up, 1'b0);
        sig_det = 1'b1;
        tick(SET - 2);
        sig_det = 1'b0;
        tick(1);
        sig_det = 1'b1;
        tick(SET - 1);
        chk("R4 timer restarted", link_ready, 1'b0);
        tick(1);
        chk("R4 ready after full rerun", link_ready, 1'b1);
        sig_det = 1'b0;
        tick(1);
        chk("R4 drop from ready", link_ready, 1'b0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_settle_an_off();
        t_lock_loss();
        t_an_wait();
        t_drop_midcount();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule